// File: doc/BRIEF.md
# SMI Global Status Aggregator

This block collects power-management events into a 16-bit global status register and raises a system management interrupt request when any of them is both pending and enabled. Six event sources feed it: a write to the APM command port, a summary of a separate device-status vector, a once-per-minute software timer, a 64 ms timer, a master-abort strobe from the I/O controller's PCI master and a write of 1 to the BIOS global-release bit. A matching 16-bit global enable register selects which pending events may request an interrupt. A master SMI enable input must also be on.

Software reaches both registers through a small register port with offsets. The status register sits at offset 20h and the enable register at offset 22h. Status bits are cleared by writing 1 to them. The device summary bit is the exception: it only follows its source vector. Both timers advance on a clock-enable tick input. Their periods are parameters, counted in ticks, so a short period can stand in for 64 ms and one minute. All state belongs to the standby domain and is cleared only by the resume-well reset.

Top module: `smi_status_agg`

## Requirements
- R1: After resume-well reset (`rsmRstN` low), a read of offset 20h returns 0 and a read of offset 22h returns 0. `smiOut` is 0.
- R2: Enable register bits 11:0 at offset 22h are written and read back as written. Bits 15:12 always read 0, whatever is written to them.
- R3: A one-cycle `apmWrStrobe` sets status bit 5 from the next cycle on. Writing 1 to bit 5 at offset 20h clears it. Writing 0 to it leaves it set.
- R4: Status bit 4 reads as the OR of all bits of `devStsIn`. Writing 1 to bit 4 does not clear it. It reads 0 once every bit of `devStsIn` is 0.
- R5: Status bit 1 sets on the clock edge that ends every `MS_TICKS`-th cycle with `tickIn` high, counted from reset. Cycles with `tickIn` low do not advance the count. Writing 1 to bit 1 clears it.
- R6: Status bit 3 sets on the clock edge that ends every `MIN_TICKS`-th cycle with `tickIn` high, counted from reset. Writing 1 to bit 3 clears it.
- R7: A one-cycle `masterAbortStrobe` sets status bit 2. A one-cycle `biosRlsStrobe` sets status bit 0. Each bit is cleared by writing 1 to it.
- R8: When an event sets a status bit in the same cycle as a write-1-to-clear of that bit, the bit is set after that edge.
- R9: `smiOut` is 1 exactly when `smiMasterEn` is 1 and some status bit n in 5:0 is set while enable bit n is set.
- R10: Status bits 15:6 read 0. A read of any offset other than 20h and 22h returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby-domain clock |
| rsmRstN | input | 1 | Resume-well reset, active low, asynchronous |
| tickIn | input | 1 | Clock-enable tick that advances both event timers |
| regAddr | input | 8 | Register offset from the I/O base |
| regWrEn | input | 1 | Write strobe for the register port |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for `regAddr`, combinational |
| apmWrStrobe | input | 1 | Pulse on a write to the APM command port |
| devStsIn | input | DEV_W | Device-status vector that is summarised into bit 4 |
| masterAbortStrobe | input | 1 | Pulse when an I/O controller PCI cycle is master-aborted |
| biosRlsStrobe | input | 1 | Pulse on a write of 1 to the global-release bit |
| smiMasterEn | input | 1 | Master SMI enable |
| smiOut | output | 1 | System management interrupt request |

## Verification
Each event source is driven on its own and then read back. This separates a wrong bit position from a missing set path and from a clear path that ignores the written value. Timer ticks are issued with idle cycles between them and one tick short of the period, which shows that only tick cycles count and that the period is exact. A strobe that meets a clear in the same cycle shows which of the two has priority. The interrupt is tried with the master enable off, with the matching enable bit off, and with both on, which shows that all three terms of the gate are needed.

// File: rtl/smi_agg_pkg.sv
package smi_agg_pkg;
  localparam int REG_W   = 16;
  localparam int NUM_SRC = 6;
  localparam int EN_USED = 12;

  localparam int STS_BIOS = 0;
  localparam int STS_MS   = 1;
  localparam int STS_MA   = 2;
  localparam int STS_MIN  = 3;
  localparam int STS_DEV  = 4;
  localparam int STS_APM  = 5;

  typedef struct packed {
    logic stsSel;
    logic enSel;
    logic stsWr;
    logic enWr;
    logic msEvt;
    logic minEvt;
  } ctrlStrb_t;
endpackage

// File: rtl/smi_agg_timer.sv
module smi_agg_timer #(
  parameter int PERIOD = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  output logic evt
);
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cntQ;
  logic atLast;

  assign atLast = (cntQ == LAST);
  assign evt    = tick && atLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (tick) begin
      cntQ <= atLast ? '0 : cntQ + 1'b1;
    end
  end
endmodule

// File: rtl/smi_agg_ctrl.sv
module smi_agg_ctrl
  import smi_agg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int STS_OFF   = 'h20,
  parameter int EN_OFF    = 'h22,
  parameter int MS_TICKS  = 64,
  parameter int MIN_TICKS = 60000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrlStrb_t         strb
);
  localparam int NUM_TMR = 2;
  localparam int TMR_PERIOD [NUM_TMR] = '{MS_TICKS, MIN_TICKS};

  logic [NUM_TMR-1:0] tmrEvt;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    smi_agg_timer #(.PERIOD(TMR_PERIOD[t])) u_tmr (
      .clk (clk),
      .rstN(rstN),
      .tick(tickIn),
      .evt (tmrEvt[t])
    );
  end

  always_comb begin
    strb.stsSel = (regAddr == ADDR_W'(STS_OFF));
    strb.enSel  = (regAddr == ADDR_W'(EN_OFF));
    strb.stsWr  = regWrEn && strb.stsSel;
    strb.enWr   = regWrEn && strb.enSel;
    strb.msEvt  = tmrEvt[0];
    strb.minEvt = tmrEvt[1];
  end
endmodule

// File: rtl/smi_agg_dp.sv
module smi_agg_dp
  import smi_agg_pkg::*;
#(
  parameter int DEV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [REG_W-1:0] wrData,
  input  logic             apmWr,
  input  logic [DEV_W-1:0] devSts,
  input  logic             masterAbort,
  input  logic             biosRls,
  input  logic             masterEn,
  output logic [REG_W-1:0] rdData,
  output logic             smi
);
  logic [NUM_SRC-1:0] stsQ;
  logic [NUM_SRC-1:0] setVec;
  logic [NUM_SRC-1:0] stsView;
  logic [EN_USED-1:0] enQ;

  always_comb begin
    setVec           = '0;
    setVec[STS_BIOS] = biosRls;
    setVec[STS_MS]   = strb.msEvt;
    setVec[STS_MA]   = masterAbort;
    setVec[STS_MIN]  = strb.minEvt;
    setVec[STS_APM]  = apmWr;
  end

  for (genvar b = 0; b < NUM_SRC; b++) begin : g_sts
    if (b == STS_DEV) begin : g_ro
      assign stsView[b] = |devSts;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stsQ[b] <= 1'b0;
        else       stsQ[b] <= 1'b0;
      end
    end else begin : g_w1c
      logic clrHit;
      assign clrHit     = strb.stsWr && wrData[b];
      assign stsView[b] = stsQ[b];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          stsQ[b] <= 1'b0;
        else if (setVec[b]) stsQ[b] <= 1'b1;
        else if (clrHit)    stsQ[b] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          enQ <= '0;
    else if (strb.enWr) enQ <= wrData[EN_USED-1:0];
  end

  always_comb begin
    rdData = '0;
    if (strb.stsSel)     rdData[NUM_SRC-1:0] = stsView;
    else if (strb.enSel) rdData[EN_USED-1:0] = enQ;
  end

  assign smi = masterEn && |(stsView & enQ[NUM_SRC-1:0]);
endmodule

// File: rtl/smi_status_agg.sv
module smi_status_agg
  import smi_agg_pkg::*;
#(
  parameter int DEV_W     = 8,
  parameter int MS_TICKS  = 64,
  parameter int MIN_TICKS = 60000
) (
  input  logic             clk,
  input  logic             rsmRstN,
  input  logic             tickIn,
  input  logic [7:0]       regAddr,
  input  logic             regWrEn,
  input  logic [15:0]      regWrData,
  output logic [15:0]      regRdData,
  input  logic             apmWrStrobe,
  input  logic [DEV_W-1:0] devStsIn,
  input  logic             masterAbortStrobe,
  input  logic             biosRlsStrobe,
  input  logic             smiMasterEn,
  output logic             smiOut
);
  ctrlStrb_t strb;

  smi_agg_ctrl #(
    .ADDR_W   (8),
    .STS_OFF  ('h20),
    .EN_OFF   ('h22),
    .MS_TICKS (MS_TICKS),
    .MIN_TICKS(MIN_TICKS)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rsmRstN),
    .tickIn (tickIn),
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .strb   (strb)
  );

  smi_agg_dp #(.DEV_W(DEV_W)) u_dp (
    .clk        (clk),
    .rstN       (rsmRstN),
    .strb       (strb),
    .wrData     (regWrData),
    .apmWr      (apmWrStrobe),
    .devSts     (devStsIn),
    .masterAbort(masterAbortStrobe),
    .biosRls    (biosRlsStrobe),
    .masterEn   (smiMasterEn),
    .rdData     (regRdData),
    .smi        (smiOut)
  );
endmodule

// File: rtl/smi_status_agg_chk.sv
module smi_status_agg_chk #(
  parameter int DEV_W = 8
) (
  input logic             clk,
  input logic             rsmRstN,
  input logic [7:0]       regAddr,
  input logic             regWrEn,
  input logic [15:0]      regWrData,
  input logic [15:0]      regRdData,
  input logic             apmWrStrobe,
  input logic [DEV_W-1:0] devStsIn,
  input logic             masterAbortStrobe,
  input logic             biosRlsStrobe,
  input logic             smiMasterEn,
  input logic             smiOut
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rsmRstN)
    regRdData[15:12] == 4'h0); // R2

  AST_APM_SET: assert property (@(posedge clk) disable iff (!rsmRstN)
    apmWrStrobe ##1 (regAddr == 8'h20) |-> regRdData[5]); // R3

  AST_DEV_TRACK: assert property (@(posedge clk) disable iff (!rsmRstN)
    (regAddr == 8'h20) |-> (regRdData[4] == |devStsIn)); // R4

  AST_MA_SET: assert property (@(posedge clk) disable iff (!rsmRstN)
    masterAbortStrobe ##1 (regAddr == 8'h20) |-> regRdData[2]); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rsmRstN)
    (biosRlsStrobe && regWrEn && regAddr == 8'h20 && regWrData[0])
      ##1 (regAddr == 8'h20) |-> regRdData[0]); // R8

  AST_SMI_GATE: assert property (@(posedge clk) disable iff (!rsmRstN)
    !smiMasterEn |-> !smiOut); // R9

  AST_HIGH_STS_ZERO: assert property (@(posedge clk) disable iff (!rsmRstN)
    (regAddr == 8'h20) |-> (regRdData[15:6] == 10'h0)); // R10
endmodule

bind smi_status_agg smi_status_agg_chk #(.DEV_W(DEV_W)) u_chk (
  .clk              (clk),
  .rsmRstN          (rsmRstN),
  .regAddr          (regAddr),
  .regWrEn          (regWrEn),
  .regWrData        (regWrData),
  .regRdData        (regRdData),
  .apmWrStrobe      (apmWrStrobe),
  .devStsIn         (devStsIn),
  .masterAbortStrobe(masterAbortStrobe),
  .biosRlsStrobe    (biosRlsStrobe),
  .smiMasterEn      (smiMasterEn),
  .smiOut           (smiOut)
);

// File: tb/smi_status_agg_tb.sv
`timescale 1ns/1ps
module smi_status_agg_tb;
  localparam int DEV_W = 4;
  localparam int MS_T  = 4;
  localparam int MIN_T = 10;

  logic        clk = 1'b0;
  logic        rsmRstN = 1'b0;
  logic        tickIn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = 16'h0;
  logic [15:0] regRdData;
  logic        apmWrStrobe = 1'b0;
  logic [DEV_W-1:0] devStsIn = '0;
  logic        masterAbortStrobe = 1'b0;
  logic        biosRlsStrobe = 1'b0;
  logic        smiMasterEn = 1'b0;
  logic        smiOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  smi_status_agg #(.DEV_W(DEV_W), .MS_TICKS(MS_T), .MIN_TICKS(MIN_T)) u_dut (
    .clk(clk), .rsmRstN(rsmRstN), .tickIn(tickIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .apmWrStrobe(apmWrStrobe), .devStsIn(devStsIn),
    .masterAbortStrobe(masterAbortStrobe), .biosRlsStrobe(biosRlsStrobe),
    .smiMasterEn(smiMasterEn), .smiOut(smiOut)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = 16'h0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic tickOnce();
    @(negedge clk); tickIn = 1'b1;
    @(negedge clk); tickIn = 1'b0;
    idle(1);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rdReg(8'h20, d); chk("R1 status after reset", d, 16'h0);
    rdReg(8'h22, d); chk("R1 enable after reset", d, 16'h0);
    chk("R1 smiOut after reset", {15'h0, smiOut}, 16'h0);
  endtask

  task automatic t_enable();
    logic [15:0] d;
    wrReg(8'h22, 16'hFFFF); rdReg(8'h22, d); chk("R2 enable all ones", d, 16'h0FFF);
    wrReg(8'h22, 16'hA5A); rdReg(8'h22, d); chk("R2 enable pattern", d, 16'h0A5A);
    wrReg(8'h22, 16'h0); rdReg(8'h22, d); chk("R2 enable cleared", d, 16'h0);
  endtask

  task automatic t_apm();
    logic [15:0] d;
    @(negedge clk); apmWrStrobe = 1'b1;
    @(negedge clk); apmWrStrobe = 1'b0;
    rdReg(8'h20, d); chk("R3 apm sets bit5", d, 16'h0020);
    wrReg(8'h20, 16'h0); rdReg(8'h20, d); chk("R3 write 0 keeps bit5", d, 16'h0020);
    wrReg(8'h20, 16'h0020); rdReg(8'h20, d); chk("R3 write 1 clears bit5", d, 16'h0);
  endtask

  task automatic t_dev();
    logic [15:0] d;
    @(negedge clk); devStsIn = 4'b0100;
    rdReg(8'h20, d); chk("R4 dev summary set", d, 16'h0010);
    wrReg(8'h20, 16'h0010); rdReg(8'h20, d); chk("R4 write 1 does not clear", d, 16'h0010);
    @(negedge clk); devStsIn = 4'b1001;
    rdReg(8'h20, d); chk("R4 other dev bits", d, 16'h0010);
    @(negedge clk); devStsIn = 4'b0000;
    rdReg(8'h20, d); chk("R4 dev all clear", d, 16'h0);
  endtask

  task automatic t_ms();
    logic [15:0] d;
    for (int i = 0; i < MS_T - 1; i++) tickOnce();
    rdReg(8'h20, d); chk("R5 one tick short", d & 16'h0002, 16'h0);
    tickOnce();
    rdReg(8'h20, d); chk("R5 period reached", d & 16'h0002, 16'h0002);
    wrReg(8'h20, 16'h0002); rdReg(8'h20, d); chk("R5 cleared", d & 16'h0002, 16'h0);
    idle(10);
    rdReg(8'h20, d); chk("R5 no tick no set", d & 16'h0002, 16'h0);
    for (int i = 0; i < MS_T; i++) tickOnce();
    rdReg(8'h20, d); chk("R5 second period", d & 16'h0002, 16'h0002);
    wrReg(8'h20, 16'h0002);
  endtask

  task automatic t_min();
    logic [15:0] d;
    for (int i = 0; i < MIN_T - 2 * MS_T - 1; i++) tickOnce();
    rdReg(8'h20, d); chk("R6 one tick short", d & 16'h0008, 16'h0);
    tickOnce();
    rdReg(8'h20, d); chk("R6 period reached", d & 16'h0008, 16'h0008);
    wrReg(8'h20, 16'h000A); rdReg(8'h20, d); chk("R6 cleared", d & 16'h0008, 16'h0);
  endtask

  task automatic t_ma_bios();
    logic [15:0] d;
    @(negedge clk); masterAbortStrobe = 1'b1;
    @(negedge clk); masterAbortStrobe = 1'b0;
    rdReg(8'h20, d); chk("R7 master abort bit2", d, 16'h0004);
    @(negedge clk); biosRlsStrobe = 1'b1;
    @(negedge clk); biosRlsStrobe = 1'b0;
    rdReg(8'h20, d); chk("R7 bios bit0", d, 16'h0005);
    wrReg(8'h20, 16'h0004); rdReg(8'h20, d); chk("R7 clear bit2 only", d, 16'h0001);
    wrReg(8'h20, 16'h0001); rdReg(8'h20, d); chk("R7 clear bit0", d, 16'h0);
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    @(negedge clk);
    regAddr = 8'h20; regWrData = 16'h0001; regWrEn = 1'b1; biosRlsStrobe = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = 16'h0; biosRlsStrobe = 1'b0;
    rdReg(8'h20, d); chk("R8 set wins over clear", d, 16'h0001);
    wrReg(8'h20, 16'h0001); rdReg(8'h20, d); chk("R8 later clear", d, 16'h0);
  endtask

  task automatic t_smi();
    @(negedge clk); apmWrStrobe = 1'b1;
    @(negedge clk); apmWrStrobe = 1'b0;
    wrReg(8'h22, 16'h0020);
    #1 chk("R9 master off", {15'h0, smiOut}, 16'h0);
    @(negedge clk); smiMasterEn = 1'b1;
    #1 chk("R9 all terms on", {15'h0, smiOut}, 16'h1);
    wrReg(8'h22, 16'h0FDF);
    #1 chk("R9 matching enable off", {15'h0, smiOut}, 16'h0);
    wrReg(8'h22, 16'h0020);
    #1 chk("R9 enable back on", {15'h0, smiOut}, 16'h1);
    wrReg(8'h20, 16'h0020);
    #1 chk("R9 status cleared", {15'h0, smiOut}, 16'h0);
    @(negedge clk); smiMasterEn = 1'b0;
    wrReg(8'h22, 16'h0);
  endtask

  task automatic t_other();
    logic [15:0] d;
    wrReg(8'h22, 16'h0FFF);
    rdReg(8'h24, d); chk("R10 unmapped offset", d, 16'h0);
    rdReg(8'h21, d); chk("R10 odd offset", d, 16'h0);
    wrReg(8'h20, 16'hFFC0); rdReg(8'h20, d); chk("R10 high status bits", d, 16'h0);
    wrReg(8'h22, 16'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    idle(3);
    t_reset();
    @(negedge clk); rsmRstN = 1'b1;
    idle(2);
    t_reset();
    t_enable();
    t_apm();
    t_dev();
    t_ms();
    t_min();
    t_ma_bios();
    t_set_wins();
    t_smi();
    t_other();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule